// File: doc/BRIEF.md
# PC Card host cycle interface

This block sits between the host side of a PC Card slot and the register and buffer logic of a network card. It watches the host address, the two active-low card enables, the attribute/IO select line and the four active-low strobes. Each strobe is passed through a two-flop synchronizer. The block then sorts each host cycle into one of three spaces: common memory, attribute memory or I/O. Accepted cycles go out as one request on a simple internal port, and that port has a ready handshake.

While the internal side is busy, the block stretches the host cycle with WAIT. For reads it keeps the returned word in a register and places it on the byte lanes that the card enables select. For I/O cycles it drives the I/O-read acknowledge and the 16-bit I/O indication. The 16-bit host data bus is modelled as a separate input, a separate output and one output enable per byte lane, so that the pad ring can build the bidirectional pins.

Top module: `pccard_host_if`

## Requirements
- R1: After reset, wait_n, inpack_n and iois16_n are high, both lane enables are low and req_valid is low.
- R2: The space code req_space is 2'b00 for OE/WE cycles with reg_n high, 2'b01 for OE/WE cycles with reg_n low, and 2'b10 for IORD/IOWR cycles with reg_n low. An IORD/IOWR cycle with reg_n high raises no request, asserts no acknowledge and drives nothing.
- R3: A memory cycle is accepted only below the window limit: 8192 bytes for attribute space and 114688 bytes for common space. A cycle at or above the limit raises no request.
- R4: A cycle is accepted only while at least one card enable is low. On reads, hd_oe_lo follows ce1_n low and hd_oe_hi follows ce2_n low. With both enables high, no request is raised.
- R5: Read steering and byte enables (bit 0 = low byte, bit 1 = high byte). With both enables low, hd_out carries the internal word and req_be is 2'b11. With only ce1_n low, the low lane carries the low byte for an even address (req_be 2'b01) and the high byte for an odd address (req_be 2'b10). With only ce2_n low, the high lane carries the high byte and req_be is 2'b10.
- R6: Write packing. With both enables low, req_wdata equals hd_in. With only ce1_n low, req_wdata is hd_in[7:0] copied to both bytes. With only ce2_n low, req_wdata is hd_in[15:8] copied to both bytes. req_write is 1 for writes and 0 for reads.
- R7: One host strobe produces exactly one request. While req_valid is high and req_ready is low, req_valid, req_addr and req_be stay unchanged. req_addr is the host address with bit 0 cleared.
- R8: wait_n goes low in the clock where req_valid first rises, which is the third rising edge after the strobe falls. It stays low while the request is pending and goes high at the edge where req_ready is sampled high.
- R9: After wait_n goes high, hd_out stays stable until the strobe rises, even if req_rdata changes.
- R10: The lane enables are high only during a read whose strobe is still low. They drop in the same cycle the raw strobe rises. Writes never drive them.
- R11: inpack_n is low only during an accepted I/O read while iord_n is low.
- R12: iois16_n is low during an accepted I/O cycle with both enables low. It stays high for 8-bit I/O cycles and for memory cycles, and it is high again once the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | AW | Host address |
| ce1_n | input | 1 | Low byte lane enable, active low |
| ce2_n | input | 1 | High byte lane enable, active low |
| reg_n | input | 1 | Attribute / I/O select, active low |
| oe_n | input | 1 | Memory read strobe, active low |
| we_n | input | 1 | Memory write strobe, active low |
| iord_n | input | 1 | I/O read strobe, active low |
| iowr_n | input | 1 | I/O write strobe, active low |
| hd_in | input | DW | Host data from the pins |
| hd_out | output | DW | Host data toward the pins |
| hd_oe_lo | output | 1 | Output enable for the low byte lane |
| hd_oe_hi | output | 1 | Output enable for the high byte lane |
| inpack_n | output | 1 | I/O read acknowledge, active low |
| iois16_n | output | 1 | 16-bit I/O indication, active low |
| wait_n | output | 1 | Wait-state request, active low |
| req_valid | output | 1 | Internal request pending |
| req_write | output | 1 | Request is a write |
| req_space | output | 2 | Space code of the request |
| req_addr | output | AW | Word-aligned request address |
| req_be | output | 2 | Byte enables of the request |
| req_wdata | output | DW | Packed write data |
| req_rdata | input | DW | Read data from the internal side |
| req_ready | input | 1 | Internal side completes the request |

## Verification
The checker watches these rules on every cycle:
- WAIT is low whenever a request is pending, and it releases right after the handshake.
- A stalled request keeps its address and byte enables.
- The acknowledge and the lane enables appear only under a low read strobe.
- Read data stays still once WAIT has released.
- The 16-bit I/O indication agrees with the byte enables.

Some behaviour only the directed scenarios can show:
- the space decode and the window limits;
- the lane steering for all four enable pairs and both address parities;
- write packing;
- ignored I/O cycles;
- the exact edge on which WAIT first falls when ready arrives after a random delay.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

    typedef enum logic [1:0] {
        SP_COMMON = 2'b00,
        SP_ATTR   = 2'b01,
        SP_IO     = 2'b10
    } space_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BUSY,
        ST_HOLD
    } state_e;

endpackage

// File: rtl/pcc_sync.sv
module pcc_sync #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Two flops per bit; inactive (high) after reset.
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [1:0] ff_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff_q <= 2'b11;
            else        ff_q <= {ff_q[0], d[i]};
        end
        assign q[i] = ff_q[1];
    end
endmodule

// File: rtl/pcc_decode.sv
module pcc_decode
    import pcc_pkg::*;
#(
    parameter int AW           = 17,
    parameter int ATTR_BYTES   = 8192,
    parameter int COMMON_BYTES = 114688
) (
    input  logic [AW-1:0] addr,
    input  logic          ce1_n,
    input  logic          ce2_n,
    input  logic          reg_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic          iord_n,
    input  logic          iowr_n,
    output logic          hit,
    output space_e        space,
    output logic          is_write,
    output logic [1:0]    be
);
    localparam logic [AW:0] ATTR_LIM   = ATTR_BYTES[AW:0];
    localparam logic [AW:0] COMMON_LIM = COMMON_BYTES[AW:0];

    logic mem_rd, mem_wr, io_rd, io_wr, any_ce, range_ok;

    always_comb begin
        mem_rd   = ~oe_n;
        mem_wr   = ~we_n;
        io_rd    = ~iord_n & ~reg_n;
        io_wr    = ~iowr_n & ~reg_n;
        any_ce   = ~ce1_n | ~ce2_n;
        if (io_rd | io_wr) begin
            space    = SP_IO;
            range_ok = 1'b1;
            is_write = io_wr & ~io_rd;
        end else begin
            space    = reg_n ? SP_COMMON : SP_ATTR;
            range_ok = reg_n ? ({1'b0, addr} < COMMON_LIM) : ({1'b0, addr} < ATTR_LIM);
            is_write = mem_wr & ~mem_rd;
        end
        hit = any_ce & (io_rd | io_wr | mem_rd | mem_wr) & range_ok;
        if (~ce1_n & ~ce2_n) be = 2'b11;
        else if (~ce1_n)     be = addr[0] ? 2'b10 : 2'b01;
        else                 be = 2'b10;
    end
endmodule

// File: rtl/pcc_lanes.sv
module pcc_lanes #(
    parameter int DW = 16
) (
    input  logic          lo_en,
    input  logic          hi_en,
    input  logic [DW-1:0] hd_in,
    input  logic [1:0]    rd_be,
    input  logic [DW-1:0] rdata,
    output logic [DW-1:0] wdata,
    output logic [DW-1:0] hd_out
);
    localparam int BW = DW / 2;

    always_comb begin
        if (lo_en && hi_en) wdata = hd_in;
        else if (lo_en)     wdata = {hd_in[BW-1:0], hd_in[BW-1:0]};
        else                wdata = {hd_in[DW-1:BW], hd_in[DW-1:BW]};
        // A lone odd byte on the low lane comes from the upper half of the word.
        hd_out = {rdata[DW-1:BW], (rd_be == 2'b10) ? rdata[DW-1:BW] : rdata[BW-1:0]};
    end
endmodule

// File: rtl/pccard_host_if.sv
module pccard_host_if
    import pcc_pkg::*;
#(
    parameter int AW           = 17,
    parameter int DW           = 16,
    parameter int ATTR_BYTES   = 8192,
    parameter int COMMON_BYTES = 114688
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] host_addr,
    input  logic          ce1_n,
    input  logic          ce2_n,
    input  logic          reg_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic          iord_n,
    input  logic          iowr_n,
    input  logic [DW-1:0] hd_in,
    output logic [DW-1:0] hd_out,
    output logic          hd_oe_lo,
    output logic          hd_oe_hi,
    output logic          inpack_n,
    output logic          iois16_n,
    output logic          wait_n,
    output logic          req_valid,
    output logic          req_write,
    output logic [1:0]    req_space,
    output logic [AW-1:0] req_addr,
    output logic [1:0]    req_be,
    output logic [DW-1:0] req_wdata,
    input  logic [DW-1:0] req_rdata,
    input  logic          req_ready
);
    localparam int NSYNC = 7;

    typedef struct packed {
        state_e        st;
        space_e        space;
        logic          wr;
        logic [1:0]    be;
        logic          lane_lo;
        logic          lane_hi;
        logic          wait_n;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [DW-1:0] rdata;
    } regs_t;

    regs_t q, d;

    logic [NSYNC-1:0] raw_s, syn_s;
    logic s_ce1, s_ce2, s_reg, s_oe, s_we, s_iord, s_iowr;
    logic dec_hit, dec_wr, strobe_on, rd_raw, drive;
    space_e dec_space;
    logic [1:0]    dec_be;
    logic [DW-1:0] pack_wdata;

    assign raw_s = {ce1_n, ce2_n, reg_n, oe_n, we_n, iord_n, iowr_n};
    assign {s_ce1, s_ce2, s_reg, s_oe, s_we, s_iord, s_iowr} = syn_s;

    pcc_sync #(.W(NSYNC)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_s), .q(syn_s)
    );

    pcc_decode #(.AW(AW), .ATTR_BYTES(ATTR_BYTES), .COMMON_BYTES(COMMON_BYTES)) u_decode (
        .addr(host_addr), .ce1_n(s_ce1), .ce2_n(s_ce2), .reg_n(s_reg),
        .oe_n(s_oe), .we_n(s_we), .iord_n(s_iord), .iowr_n(s_iowr),
        .hit(dec_hit), .space(dec_space), .is_write(dec_wr), .be(dec_be)
    );

    pcc_lanes #(.DW(DW)) u_lanes (
        .lo_en(~s_ce1), .hi_en(~s_ce2), .hd_in(hd_in), .rd_be(q.be),
        .rdata(q.rdata), .wdata(pack_wdata), .hd_out(hd_out)
    );

    // Synchronized strobe of the cycle in progress.
    always_comb begin
        if (q.space == SP_IO) strobe_on = q.wr ? ~s_iowr : ~s_iord;
        else                  strobe_on = q.wr ? ~s_we   : ~s_oe;
    end

    always_comb begin
        d = q;
        case (q.st)
            ST_IDLE: if (dec_hit) begin
                d.st      = ST_BUSY;
                d.space   = dec_space;
                d.wr      = dec_wr;
                d.be      = dec_be;
                d.lane_lo = ~s_ce1;
                d.lane_hi = ~s_ce2;
                d.wait_n  = 1'b0;
                d.addr    = {host_addr[AW-1:1], 1'b0};
                d.wdata   = pack_wdata;
            end
            ST_BUSY: if (req_ready) begin
                d.st     = ST_HOLD;
                d.wait_n = 1'b1;
                if (!q.wr) d.rdata = req_rdata;
            end
            ST_HOLD: if (!strobe_on) d.st = ST_IDLE;
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.st     <= ST_IDLE;
            q.space  <= SP_COMMON;
            q.wait_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    // Lane drive follows the raw read strobe so the bus is released at once.
    assign rd_raw    = (q.space == SP_IO) ? ~iord_n : ~oe_n;
    assign drive     = (q.st != ST_IDLE) & ~q.wr & rd_raw;
    assign hd_oe_lo  = drive & q.lane_lo;
    assign hd_oe_hi  = drive & q.lane_hi;
    assign inpack_n  = ~(drive & (q.space == SP_IO));
    assign iois16_n  = ~((q.st != ST_IDLE) & (q.space == SP_IO) & q.lane_lo & q.lane_hi);
    assign wait_n    = q.wait_n;
    assign req_valid = (q.st == ST_BUSY);
    assign req_write = q.wr;
    assign req_space = q.space;
    assign req_addr  = q.addr;
    assign req_be    = q.be;
    assign req_wdata = q.wdata;
endmodule

// File: rtl/pcc_host_chk.sv
module pcc_host_chk #(
    parameter int AW = 17,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          oe_n,
    input logic          iord_n,
    input logic          wait_n,
    input logic          inpack_n,
    input logic          iois16_n,
    input logic          hd_oe_lo,
    input logic          hd_oe_hi,
    input logic [DW-1:0] hd_out,
    input logic          req_valid,
    input logic          req_ready,
    input logic [AW-1:0] req_addr,
    input logic [1:0]    req_be,
    input logic [1:0]    req_space
);
    // R8
    wait_on_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> !wait_n);

    // R8
    wait_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> wait_n);

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_be));

    // R11
    inpack_io_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !inpack_n |-> !iord_n);

    // R10
    drive_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hd_oe_lo || hd_oe_hi) |-> (!oe_n || !iord_n));

    // R9
    read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hd_oe_lo || hd_oe_hi) && $past(hd_oe_lo || hd_oe_hi) && wait_n && $past(wait_n)
        |-> $stable(hd_out));

    // R12
    iois_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && (req_space == 2'b10) |-> (iois16_n == (req_be != 2'b11)));
endmodule

bind pccard_host_if pcc_host_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .iord_n(iord_n), .wait_n(wait_n),
    .inpack_n(inpack_n), .iois16_n(iois16_n), .hd_oe_lo(hd_oe_lo), .hd_oe_hi(hd_oe_hi),
    .hd_out(hd_out), .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_be(req_be), .req_space(req_space)
);

// File: tb/pccard_host_if_bench.sv
`timescale 1ns/1ps
module pccard_host_if_bench;
    localparam int AW = 17;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic ce1_n = 1'b1, ce2_n = 1'b1, reg_n = 1'b1;
    logic oe_n = 1'b1, we_n = 1'b1, iord_n = 1'b1, iowr_n = 1'b1;
    logic [DW-1:0] hd_in = '0, hd_out, req_wdata, req_rdata = '0;
    logic hd_oe_lo, hd_oe_hi, inpack_n, iois16_n, wait_n;
    logic req_valid, req_write, req_ready = 1'b0;
    logic [1:0] req_space, req_be;
    logic [AW-1:0] req_addr;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    // Values captured by the access task.
    bit got_req, wait_ok, hold_ok, off_ok, idle_ok;
    logic [1:0] c_space, c_be;
    logic c_wr, c_lo, c_hi, c_inpack, c_iois;
    logic [AW-1:0] c_addr;
    logic [DW-1:0] c_wdata, c_hd;

    always #2.5 clk = ~clk;

    pccard_host_if u_pccard_host_if (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .ce1_n(ce1_n), .ce2_n(ce2_n),
        .reg_n(reg_n), .oe_n(oe_n), .we_n(we_n), .iord_n(iord_n), .iowr_n(iowr_n),
        .hd_in(hd_in), .hd_out(hd_out), .hd_oe_lo(hd_oe_lo), .hd_oe_hi(hd_oe_hi),
        .inpack_n(inpack_n), .iois16_n(iois16_n), .wait_n(wait_n), .req_valid(req_valid),
        .req_write(req_write), .req_space(req_space), .req_addr(req_addr), .req_be(req_be),
        .req_wdata(req_wdata), .req_rdata(req_rdata), .req_ready(req_ready)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic set_strobe(input bit io, input bit wr, input logic v);
        if (io) begin if (wr) iowr_n = v; else iord_n = v; end
        else    begin if (wr) we_n   = v; else oe_n   = v; end
    endtask

    task automatic access(input bit io, input bit wr, input logic rg, input logic c1,
                          input logic c2, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                          input logic [DW-1:0] rd, input int dly);
        got_req = 0; wait_ok = 1; hold_ok = 1;
        @(negedge clk);
        host_addr = a; reg_n = rg; ce1_n = c1; ce2_n = c2; hd_in = wd;
        set_strobe(io, wr, 1'b0);
        for (int i = 0; i < 6 && !got_req; i++) begin
            @(negedge clk);
            if (req_valid) got_req = 1;
            else if (!wait_n) wait_ok = 0;
        end
        if (got_req) begin
            c_space = req_space; c_be = req_be; c_wr = req_write;
            c_addr = req_addr; c_wdata = req_wdata;
            if (wait_n) wait_ok = 0;
            for (int i = 0; i < dly; i++) begin
                @(negedge clk);
                if (wait_n || !req_valid) wait_ok = 0;
            end
            req_ready = 1'b1; req_rdata = rd;
            @(negedge clk);
            req_ready = 1'b0; req_rdata = ~rd;
            if (!wait_n || req_valid) wait_ok = 0;
            c_hd = hd_out; c_lo = hd_oe_lo; c_hi = hd_oe_hi;
            c_inpack = inpack_n; c_iois = iois16_n;
            repeat (2) @(negedge clk);
            if (hd_out !== c_hd || hd_oe_lo !== c_lo || hd_oe_hi !== c_hi) hold_ok = 0;
        end else begin
            c_lo = hd_oe_lo; c_hi = hd_oe_hi; c_inpack = inpack_n; c_iois = iois16_n;
        end
        set_strobe(io, wr, 1'b1);
        #1;
        off_ok = !hd_oe_lo && !hd_oe_hi && inpack_n;
        repeat (4) @(negedge clk);
        ce1_n = 1'b1; ce2_n = 1'b1; reg_n = 1'b1;
        idle_ok = iois16_n && wait_n && !req_valid;
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 wait_n after reset", wait_n, 1);
        chk("R1 inpack_n after reset", inpack_n, 1);
        chk("R1 iois16_n after reset", iois16_n, 1);
        chk("R1 lane enables after reset", {hd_oe_hi, hd_oe_lo}, 0);
        chk("R1 req_valid after reset", req_valid, 0);
    endtask

    task automatic t_read_lanes;
        for (int m = 0; m < 8; m++) begin
            logic c1, c2, odd;
            logic [AW-1:0] a;
            logic [DW-1:0] rd;
            logic [1:0] ebe;
            c1 = m[0]; c2 = m[1]; odd = m[2];
            a = 17'h00100 | AW'(odd);
            rd = 16'hA5C3 + 16'(m * 16'h1111);
            access(0, 0, 1'b1, c1, c2, a, '0, rd, 1);
            chk("R4 request when a lane is enabled", got_req, !(c1 && c2));
            if (!(c1 && c2)) begin
                ebe = (!c1 && !c2) ? 2'b11 : (!c1 ? (odd ? 2'b10 : 2'b01) : 2'b10);
                chk("R2 common space code", c_space, 2'b00);
                chk("R4 low lane enable", c_lo, !c1);
                chk("R4 high lane enable", c_hi, !c2);
                chk("R5 byte enables", c_be, ebe);
                chk("R6 read flag", c_wr, 0);
                chk("R7 word address", c_addr, a & ~17'h1);
                if (!c1) chk("R5 low lane data", c_hd[7:0],
                             (c2 && odd) ? rd[15:8] : rd[7:0]);
                if (!c2) chk("R5 high lane data", c_hd[15:8], rd[15:8]);
                chk("R9 data held after wait release", hold_ok, 1);
                chk("R8 wait timing", wait_ok, 1);
                chk("R12 no 16-bit flag on memory", c_iois, 1);
            end else begin
                chk("R4 no drive with both enables high", {c_hi, c_lo}, 0);
            end
            chk("R10 release on strobe rise", off_ok, 1);
        end
    endtask

    task automatic t_attr_range;
        access(0, 0, 1'b0, 1'b0, 1'b0, 17'h00040, '0, 16'h1234, 0);
        chk("R2 attribute space code", c_space, 2'b01);
        chk("R2 attribute read request", got_req, 1);
        access(0, 0, 1'b0, 1'b0, 1'b0, 17'd8192, '0, 16'h1234, 0);
        chk("R3 attribute limit rejects", got_req, 0);
        chk("R3 no drive beyond attribute window", {c_hi, c_lo}, 0);
        access(0, 0, 1'b1, 1'b0, 1'b0, 17'd114688, '0, 16'h1234, 0);
        chk("R3 common limit rejects", got_req, 0);
        access(0, 0, 1'b1, 1'b0, 1'b0, 17'd114686, '0, 16'h4321, 0);
        chk("R3 last common word accepted", got_req, 1);
        chk("R3 last common word data", c_hd, 16'h4321);
    endtask

    task automatic t_writes;
        for (int m = 0; m < 3; m++) begin
            logic c1, c2;
            logic [DW-1:0] wd, ew;
            c1 = (m == 2); c2 = (m == 1);
            wd = 16'h9E21 + 16'(m);
            ew = (m == 0) ? wd : ((m == 1) ? {wd[7:0], wd[7:0]} : {wd[15:8], wd[15:8]});
            access(0, 1, 1'b1, c1, c2, 17'h00200, wd, '0, 2);
            chk("R6 write request", got_req, 1);
            chk("R6 write flag", c_wr, 1);
            chk("R6 packed write data", c_wdata, ew);
            chk("R5 write byte enables", c_be, (m == 0) ? 2'b11 : ((m == 1) ? 2'b01 : 2'b10));
            chk("R10 no drive on writes", {c_hi, c_lo}, 0);
            chk("R8 wait on write", wait_ok, 1);
        end
    endtask

    task automatic t_io;
        access(1, 0, 1'b0, 1'b0, 1'b0, 17'h00300, '0, 16'hBEEF, 1);
        chk("R2 I/O space code", c_space, 2'b10);
        chk("R11 acknowledge on 16-bit I/O read", c_inpack, 0);
        chk("R12 16-bit flag on I/O read", c_iois, 0);
        chk("R5 I/O read data", c_hd, 16'hBEEF);
        chk("R10 acknowledge and lanes released", off_ok, 1);
        chk("R12 16-bit flag cleared at idle", idle_ok, 1);
        access(1, 0, 1'b0, 1'b0, 1'b1, 17'h00301, '0, 16'h7A5B, 0);
        chk("R11 acknowledge on 8-bit I/O read", c_inpack, 0);
        chk("R12 no 16-bit flag on 8-bit I/O", c_iois, 1);
        chk("R5 odd I/O byte on low lane", c_hd[7:0], 8'h7A);
        access(1, 1, 1'b0, 1'b0, 1'b0, 17'h00302, 16'h0F0E, '0, 0);
        chk("R11 no acknowledge on I/O write", c_inpack, 1);
        chk("R12 16-bit flag on I/O write", c_iois, 0);
        chk("R6 I/O write data", c_wdata, 16'h0F0E);
        access(1, 0, 1'b1, 1'b0, 1'b0, 17'h00300, '0, 16'h5555, 0);
        chk("R2 I/O strobe with reg_n high ignored", got_req, 0);
        chk("R11 no acknowledge when not selected", c_inpack, 1);
        chk("R2 no drive when not selected", {c_hi, c_lo}, 0);
    endtask

    task automatic t_wait_random;
        for (int k = 0; k < 8; k++) begin
            int dly;
            dly = int'($urandom_range(0, 6));
            access(0, 0, 1'b1, 1'b0, 1'b0, 17'h00400 + AW'(2 * k), '0, 16'hC000 + 16'(k), dly);
            chk("R8 wait held until ready then released", wait_ok, 1);
            chk("R7 single request per strobe", idle_ok, 1);
            chk("R9 stable data after release", hold_ok, 1);
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_read_lanes();
        t_attr_range();
        t_writes();
        t_io();
        t_wait_random();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule